// File: doc/BRIEF.md
# Ramp Oscillator Delay Tap Generator

This block holds a small bank of ramp oscillators and turns the output of a chosen oscillator into a delay-line read request. Each ramp is a fixed-point phase counted in memory locations, with an integer part and a fractional part. It advances by a programmable rate on every sample tick and wraps inside a power-of-two span set by a 2-bit size code. Pitch shifters and chorus voices use it to sweep a read pointer through a delay line. The integer part of the phase, added to a caller-supplied base, gives the address to read. The fractional part gives the weight for a two-point linear interpolation.

Each read request carries a 6-bit control field. The field can pick a second pointer half a span ahead of the first. It can complement the address offset or the coefficient. It can swap the interpolation weight for a trapezoidal crossfade weight, which reaches zero exactly where a pointer jumps. It can also capture the oscillator value, so that later requests in the same sample see one consistent snapshot while the ramp keeps moving. A configuration strobe sets a ramp's rate and span and restarts it. A separate restart request forces a single ramp back to zero.

Top module: `ramp_lfo_addr_gen`

## Requirements
- R1: The size code selects a span of 512, 1024, 2048 or 4096 locations for codes 0, 1, 2 and 3. The phase wraps modulo that span.
- R2: On each cycle with `smp_tick` high, a ramp's phase advances by its rate. The rate is read as locations scaled by 2^FRAC_W, so 256 is one location at the default. A `cfg_we` strobe on the selected ramp loads its rate and size code, sets its phase to zero, and takes priority over restart and tick.
- R3: `jam_req` sets the phase of the ramp named by `jam_sel` to zero and leaves every other ramp unchanged.
- R4: When control bit 1 is set, the request uses the live phase and also stores it as that ramp's snapshot. When bit 1 is clear, the request uses the stored snapshot, while the ramp itself keeps advancing.
- R5: `rd_addr` equals `acc_base` plus the integer part of the (possibly shifted) phase, modulo 2^ADDR_W. `rd_coef` equals the fractional part, where 1.0 is written as 2^FRAC_W.
- R6: When control bit 2 is set, `rd_coef` is 1.0 minus the value it would otherwise carry (2^FRAC_W minus that value).
- R7: When control bit 3 is set, the address offset is (span - 1) minus the integer part.
- R8: When control bit 4 is set, half a span is added to the phase, modulo the span, before the address, the fraction and the crossfade weight are formed.
- R9: `rd_xfade` is the crossfade weight. It rises as phase/(span/4) over the first quarter (rounded down), holds at 1.0 over the middle half, and falls as (span - phase)/(span/4) over the last quarter. When control bit 5 is set, `rd_coef` carries this weight in place of the fraction.
- R10: Control bit 0 has no effect on any output.
- R11: The outputs are registered. `rd_valid` is high in exactly the cycle after a cycle with `acc_valid` high. After reset, every phase, rate, snapshot and size code is zero and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_tick | input | 1 | Sample strobe; advances every ramp |
| cfg_we | input | 1 | Load rate and size code into one ramp |
| cfg_sel | input | SEL_W | Ramp selected for the load |
| cfg_rate | input | RATE_W | Phase increment per sample |
| cfg_amp | input | AMP_W | Span size code |
| jam_req | input | 1 | Restart one ramp at phase zero |
| jam_sel | input | SEL_W | Ramp selected for the restart |
| acc_valid | input | 1 | Read request strobe |
| acc_sel | input | SEL_W | Ramp used by the request |
| acc_ctl | input | 6 | Per-request control field |
| acc_base | input | ADDR_W | Base address of the delay region |
| rd_valid | output | 1 | Result valid, one cycle after the request |
| rd_addr | output | ADDR_W | Base plus offset |
| rd_coef | output | FRAC_W+1 | Interpolation or crossfade coefficient |
| rd_xfade | output | FRAC_W+1 | Crossfade weight of the used phase |

## Verification
The hardest case to reach from the ports is a stored snapshot that differs from the live phase. The ramp only moves on sample ticks, so the bench captures the phase with bit 1 set, issues a tick, and then reads once with bit 1 clear and once with it set. The two results must differ by exactly one rate step. The falling quarter of the crossfade and the wrap of the span are reached by reloading a ramp with a large rate, so that a few ticks carry it past three quarters of the span and then across the wrap. A reload of a ramp that is mid-sweep shows that loading restarts the phase.

// File: rtl/ramp_lfo_pkg.sv
package ramp_lfo_pkg;

   localparam int CTL_W = 6;

   // Per-request control field, most significant bit first.
   typedef struct packed {
      logic xfade_sel;   // bit 5: coefficient carries crossfade weight
      logic second_ptr;  // bit 4: add half a span
      logic cpl_addr;    // bit 3: complement address offset
      logic cpl_coef;    // bit 2: coefficient becomes 1.0 - value
      logic latch;       // bit 1: use and store live phase
      logic spare0;      // bit 0: no function for ramps
   } acc_ctl_t;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ramp_osc.sv
module ramp_osc #(
   parameter int RATE_W        = 16,
   parameter int AMP_W         = 2,
   parameter int MIN_SPAN_LOG2 = 9,
   parameter int FRAC_W        = 8,
   localparam int INT_W        = MIN_SPAN_LOG2 + (1 << AMP_W) - 1,
   localparam int PH_W         = INT_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [RATE_W-1:0] rate_in,
   input  logic [AMP_W-1:0]  amp_in,
   input  logic              jam,
   input  logic              tick,
   output logic [PH_W-1:0]   phase,
   output logic [AMP_W-1:0]  amp_code
);

   localparam int WW = PH_W + 1;

   logic [RATE_W-1:0] rate_q;
   logic [WW-1:0]     span_w;
   logic [WW-1:0]     mask_w;
   logic [WW-1:0]     sum_w;

   always_comb begin
      span_w = WW'(1) << (MIN_SPAN_LOG2 + FRAC_W + int'(amp_code));
      mask_w = span_w - WW'(1);
      sum_w  = {1'b0, phase} + WW'(rate_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= '0;
         rate_q   <= '0;
         amp_code <= '0;
      end else if (load) begin
         rate_q   <= rate_in;
         amp_code <= amp_in;
         phase    <= '0;
      end else if (jam) begin
         phase <= '0;
      end else if (tick) begin
         phase <= PH_W'(sum_w & mask_w);
      end
   end

endmodule

// File: rtl/ramp_tap.sv
module ramp_tap
   import ramp_lfo_pkg::*;
#(
   parameter int AMP_W         = 2,
   parameter int MIN_SPAN_LOG2 = 9,
   parameter int FRAC_W        = 8,
   parameter int ADDR_W        = 15,
   localparam int INT_W        = MIN_SPAN_LOG2 + (1 << AMP_W) - 1,
   localparam int PH_W         = INT_W + FRAC_W,
   localparam int CW           = FRAC_W + 1
) (
   input  logic [PH_W-1:0]   phase_src,
   input  logic [AMP_W-1:0]  amp_code,
   input  acc_ctl_t          ctl,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] addr,
   output logic [CW-1:0]     coef,
   output logic [CW-1:0]     xfade
);

   localparam int WW = PH_W + 1;
   localparam logic [CW-1:0] ONE = CW'(1) << FRAC_W;

   logic [WW-1:0]     span_w, mask_w, half_w, qtr_w;
   logic [WW-1:0]     raw_w, sum_w, pos_w, xw;
   logic [INT_W-1:0]  intg, span_m1, ofs;
   logic [FRAC_W-1:0] frac;
   logic [CW-1:0]     interp;
   int                sh;

   always_comb begin
      span_w  = WW'(1) << (MIN_SPAN_LOG2 + FRAC_W + int'(amp_code));
      mask_w  = span_w - WW'(1);
      half_w  = span_w >> 1;
      qtr_w   = span_w >> 2;
      raw_w   = {1'b0, phase_src} & mask_w;
      sum_w   = raw_w + half_w;
      pos_w   = ctl.second_ptr ? (sum_w & mask_w) : raw_w;

      intg    = pos_w[PH_W-1:FRAC_W];
      frac    = pos_w[FRAC_W-1:0];
      span_m1 = mask_w[PH_W-1:FRAC_W];
      ofs     = ctl.cpl_addr ? (span_m1 - intg) : intg;
      addr    = base + ADDR_W'(ofs);

      sh = MIN_SPAN_LOG2 + int'(amp_code) - 2;
      if (pos_w < qtr_w)
         xw = pos_w >> sh;
      else if (pos_w < (span_w - qtr_w))
         xw = WW'(ONE);
      else
         xw = (span_w - pos_w) >> sh;
      xfade = CW'(xw);

      interp = ctl.xfade_sel ? xfade : {1'b0, frac};
      coef   = ctl.cpl_coef ? (ONE - interp) : interp;
   end

endmodule

// File: rtl/ramp_lfo_addr_gen.sv
module ramp_lfo_addr_gen
   import ramp_lfo_pkg::*;
#(
   parameter int NUM_RAMPS     = 2,
   parameter int RATE_W        = 16,
   parameter int AMP_W         = 2,
   parameter int MIN_SPAN_LOG2 = 9,
   parameter int FRAC_W        = 8,
   parameter int ADDR_W        = 15,
   localparam int SEL_W        = sel_width(NUM_RAMPS),
   localparam int INT_W        = MIN_SPAN_LOG2 + (1 << AMP_W) - 1,
   localparam int PH_W         = INT_W + FRAC_W,
   localparam int CW           = FRAC_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_tick,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic [AMP_W-1:0]  cfg_amp,
   input  logic              jam_req,
   input  logic [SEL_W-1:0]  jam_sel,
   input  logic              acc_valid,
   input  logic [SEL_W-1:0]  acc_sel,
   input  logic [CTL_W-1:0]  acc_ctl,
   input  logic [ADDR_W-1:0] acc_base,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [CW-1:0]     rd_coef,
   output logic [CW-1:0]     rd_xfade
);

   initial begin
      assert (NUM_RAMPS >= 1) else $error("NUM_RAMPS must be at least 1");
      assert (ADDR_W >= INT_W) else $error("ADDR_W narrower than largest span");
      assert (RATE_W <= PH_W) else $error("RATE_W wider than phase");
      assert (MIN_SPAN_LOG2 >= 2) else $error("span too small for quarters");
      assert (FRAC_W >= 1) else $error("FRAC_W must be positive");
   end

   acc_ctl_t         ctl;
   logic [PH_W-1:0]  live_ph [NUM_RAMPS];
   logic [PH_W-1:0]  held_ph [NUM_RAMPS];
   logic [AMP_W-1:0] code    [NUM_RAMPS];

   assign ctl = acc_ctl_t'(acc_ctl);

   for (genvar i = 0; i < NUM_RAMPS; i++) begin : g_ramp
      ramp_osc #(
         .RATE_W       (RATE_W),
         .AMP_W        (AMP_W),
         .MIN_SPAN_LOG2(MIN_SPAN_LOG2),
         .FRAC_W       (FRAC_W)
      ) u_osc (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (cfg_we && (cfg_sel == SEL_W'(i))),
         .rate_in (cfg_rate),
         .amp_in  (cfg_amp),
         .jam     (jam_req && (jam_sel == SEL_W'(i))),
         .tick    (smp_tick),
         .phase   (live_ph[i]),
         .amp_code(code[i])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)
            held_ph[i] <= '0;
         else if (acc_valid && ctl.latch && (acc_sel == SEL_W'(i)))
            held_ph[i] <= live_ph[i];
      end
   end

   logic [PH_W-1:0]   sel_live, sel_held, src_ph;
   logic [AMP_W-1:0]  sel_code;
   logic [ADDR_W-1:0] t_addr;
   logic [CW-1:0]     t_coef, t_xf;

   always_comb begin
      sel_live = '0;
      sel_held = '0;
      sel_code = '0;
      for (int k = 0; k < NUM_RAMPS; k++) begin
         if (acc_sel == SEL_W'(k)) begin
            sel_live = live_ph[k];
            sel_held = held_ph[k];
            sel_code = code[k];
         end
      end
      src_ph = ctl.latch ? sel_live : sel_held;
   end

   ramp_tap #(
      .AMP_W        (AMP_W),
      .MIN_SPAN_LOG2(MIN_SPAN_LOG2),
      .FRAC_W       (FRAC_W),
      .ADDR_W       (ADDR_W)
   ) u_tap (
      .phase_src(src_ph),
      .amp_code (sel_code),
      .ctl      (ctl),
      .base     (acc_base),
      .addr     (t_addr),
      .coef     (t_coef),
      .xfade    (t_xf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_addr  <= '0;
         rd_coef  <= '0;
         rd_xfade <= '0;
      end else begin
         rd_valid <= acc_valid;
         if (acc_valid) begin
            rd_addr  <= t_addr;
            rd_coef  <= t_coef;
            rd_xfade <= t_xf;
         end
      end
   end

endmodule

// File: rtl/ramp_lfo_addr_gen_chk.sv
module ramp_lfo_addr_gen_chk #(
   parameter int FRAC_W = 8,
   localparam int CW    = FRAC_W + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          acc_valid,
   input logic [5:0]    acc_ctl,
   input logic          rd_valid,
   input logic [CW-1:0] rd_coef,
   input logic [CW-1:0] rd_xfade
);

   localparam logic [CW-1:0] ONE  = CW'(1) << FRAC_W;
   localparam logic [CW:0]   ONEW = (CW+1)'(ONE);

   assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rd_valid);

   assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rd_valid);

   assert_xfade_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_xfade <= ONE));

   assert_coef_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_coef <= ONE));

   assert_xfade_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_ctl[5] && !acc_ctl[2]) |=> (rd_coef == rd_xfade));

   assert_cpl_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_ctl[5] && acc_ctl[2]) |=>
         (({1'b0, rd_coef} + {1'b0, rd_xfade}) == ONEW));

endmodule

bind ramp_lfo_addr_gen ramp_lfo_addr_gen_chk #(.FRAC_W(FRAC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_valid(acc_valid),
   .acc_ctl  (acc_ctl),
   .rd_valid (rd_valid),
   .rd_coef  (rd_coef),
   .rd_xfade (rd_xfade)
);

// File: tb/ramp_lfo_addr_gen_tb.sv
`timescale 1ns/1ps
module ramp_lfo_addr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_tick = 1'b0;
   logic        cfg_we = 1'b0;
   logic [0:0]  cfg_sel = '0;
   logic [15:0] cfg_rate = '0;
   logic [1:0]  cfg_amp = '0;
   logic        jam_req = 1'b0;
   logic [0:0]  jam_sel = '0;
   logic        acc_valid = 1'b0;
   logic [0:0]  acc_sel = '0;
   logic [5:0]  acc_ctl = '0;
   logic [14:0] acc_base = '0;
   logic        rd_valid;
   logic [14:0] rd_addr;
   logic [8:0]  rd_coef;
   logic [8:0]  rd_xfade;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   ramp_lfo_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_rate(cfg_rate), .cfg_amp(cfg_amp),
      .jam_req(jam_req), .jam_sel(jam_sel),
      .acc_valid(acc_valid), .acc_sel(acc_sel), .acc_ctl(acc_ctl), .acc_base(acc_base),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_coef(rd_coef), .rd_xfade(rd_xfade)
   );

   // Table: ramp0 at 3.75 locations (span 512), ramp1 at 192 locations (span 4096)
   localparam int NV = 11;
   localparam int V_SEL  [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1};
   localparam int V_CTL  [NV] = '{'h02, 'h06, 'h0A, 'h12, 'h22, 'h26, 'h03,
                                  'h02, 'h12, 'h1A, 'h06};
   localparam int V_BASE [NV] = '{'h100, 'h100, 'h100, 'h100, 'h100, 'h100, 'h100,
                                  'h7F00, 'h7F00, 'h7F00, 'h7F00};
   localparam int V_ADDR [NV] = '{'h103, 'h103, 'h2FC, 'h203, 'h103, 'h103, 'h103,
                                  'h7FC0, 'h07C0, 'h063F, 'h7FC0};
   localparam int V_COEF [NV] = '{192, 64, 192, 192, 7, 249, 192, 0, 0, 0, 256};
   localparam int V_XF   [NV] = '{7, 7, 7, 256, 7, 7, 7, 48, 256, 256, 48};
   localparam string V_REQ [NV] = '{"R5", "R6", "R7", "R8", "R9", "R9", "R10",
                                    "R1", "R8", "R7", "R6"};

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick_n(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) smp_tick = 1'b1;
         @(negedge clk) smp_tick = 1'b0;
      end
   endtask

   task automatic load(input int sel, input int rate, input int amp);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 1'(sel); cfg_rate = 16'(rate); cfg_amp = 2'(amp);
      @(negedge clk) cfg_we = 1'b0;
   endtask

   task automatic jam(input int sel);
      @(negedge clk);
      jam_req = 1'b1; jam_sel = 1'(sel);
      @(negedge clk) jam_req = 1'b0;
   endtask

   // Request, then check the registered result one cycle later.
   task automatic access(input string req, input int sel, input int ctl, input int base,
                         input int e_addr, input int e_coef, input int e_xf);
      @(negedge clk);
      acc_valid = 1'b1; acc_sel = 1'(sel); acc_ctl = 6'(ctl); acc_base = 15'(base);
      @(negedge clk) acc_valid = 1'b0;
      chk({req, " valid"}, int'(rd_valid), 1);
      chk({req, " addr"},  int'(rd_addr), e_addr);
      chk({req, " coef"},  int'(rd_coef), e_coef);
      chk({req, " xfade"}, int'(rd_xfade), e_xf);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      chk("R11 reset valid", int'(rd_valid), 0);
      access("R11 reset phase", 0, 'h02, 'h55, 'h55, 0, 0);

      // R2: rates 1.25 and 64 locations, three ticks
      load(0, 'h0140, 0);
      load(1, 'h4000, 3);
      tick_n(3);

      for (int v = 0; v < NV; v++)
         access(V_REQ[v], V_SEL[v], V_CTL[v], V_BASE[v], V_ADDR[v], V_COEF[v], V_XF[v]);

      // R4: snapshot is 960, live moves to 1280 after one tick
      tick_n(1);
      access("R4 held", 0, 'h00, 'h100, 'h103, 192, 7);
      access("R4 live", 0, 'h02, 'h100, 'h105, 0, 10);

      // R3: restart ramp0 only; ramp1 is at 256 locations
      jam(0);
      access("R3 other ramp", 1, 'h02, 'h7F00, 'h0000, 0, 64);
      access("R3 jammed ramp", 0, 'h02, 'h100, 'h100, 0, 0);

      // R9/R1: falling quarter, then wrap of the span
      load(0, 'hD000, 0);
      tick_n(2);
      access("R9 falling", 0, 'h02, 0, 416, 0, 192);
      tick_n(1);
      access("R1 wrap", 0, 'h02, 0, 112, 0, 224);

      // R2/R1: reload of a moving ramp restarts it; span code 1
      load(1, 'hFFFF, 1);
      tick_n(5);
      access("R2 reload span1", 1, 'h0A, 0, 768, 251, 255);

      // R11: no request, no valid
      @(negedge clk);
      chk("R11 idle", int'(rd_valid), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule